// File: doc/BRIEF.md
# Timer Compare/Capture Channel Slice

This block is one register slice of a timer channel. A free-running counter is produced elsewhere and fed in. Its general register can work in one of two ways. As an output-compare register it acts on a channel pin whenever the counter reaches the stored value. As an input-capture register it copies the counter value when the channel pin shows a chosen edge. A 4-bit mode code selects the behaviour. A buffer-mode flag suspends both compare actions and captures, so that the register can serve as a buffer for a neighbouring register.

An 8-bit interrupt-enable register gates two request lines. One is the match/capture request of this register. The other is the counter overflow request. Both requests are level outputs of sticky flags, and each flag is cleared by its own write-one strobe. Software writes the general register, the mode code and the enable register through simple write-enable ports.

Top module: `tmr_ccu`

## Requirements
- R1: While reset is asserted, and until the first write: pin_o=0, pin_oe=0, gr_q=0, flag_o=0, irq_gr=0, irq_ovf=0, ier_rdata=0x40, and the mode code is 0000 (compare, output disabled).
- R2: An enable-register write stores bits 7, 4 and 3..0. Reading ier_rdata returns those bits with bit 6 fixed at 1 and bit 5 fixed at 0, starting the cycle after the write edge.
- R3: A mode write with bit 3 = 0 loads pin_o with mode bit 2 at the write edge. pin_oe is 1 exactly when the stored mode has bit 3 = 0 and bits 1:0 not equal to 00.
- R4: In compare mode (bit 3 = 0), with buffer mode off, a clock edge at which cnt_i equals gr_q sets flag_o after that edge.
- R5: At such a match edge, mode bits 1:0 decide the pin action: 00 leaves pin_o unchanged, 01 drives it to 0, 10 drives it to 1, and 11 inverts it. A mode write in the same cycle takes priority.
- R6: In capture mode (bit 3 = 1), pin_oe is 0. Bits 1:0 = 00 capture on a rising pin edge, and 01 capture on a falling pin edge. A capture copies cnt_i into gr_q and sets flag_o at the third clock edge after the pin changes. An edge of the other polarity leaves gr_q unchanged.
- R7: In capture mode with bits 1:0 = 10 or 11, both rising and falling pin edges capture.
- R8: While buf_mode = 1, no capture changes gr_q, no match changes pin_o, and neither event sets flag_o.
- R9: flag_clr = 1 clears flag_o at the next edge. If a match or capture occurs in the same cycle, the flag stays set.
- R10: irq_gr = flag_o AND enable bit GR_SEL (bit 2 by default). A cnt_ovf_i pulse sets an overflow flag that ovf_clr clears, and irq_ovf = that flag AND enable bit 4.
- R11: A bus write to gr_q takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | CW | Free-running counter value |
| cnt_ovf_i | input | 1 | Counter overflow pulse |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| gr_we | input | 1 | General register write enable |
| gr_wdata | input | CW | General register write data |
| ioc_we | input | 1 | Mode code write enable |
| ioc_wdata | input | 4 | Mode code write data |
| ier_we | input | 1 | Interrupt-enable write enable |
| ier_wdata | input | 8 | Interrupt-enable write data |
| buf_mode | input | 1 | Buffer mode: suspends compare actions and captures |
| flag_clr | input | 1 | Write-one clear of the match/capture flag |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| pin_o | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel pin output enable |
| gr_q | output | CW | General register value |
| flag_o | output | 1 | Match/capture flag |
| ier_rdata | output | 8 | Interrupt-enable read value |
| irq_gr | output | 1 | Match/capture interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Register writes and the pin's initial level are due one edge after the write cycle. The match flag and the pin action are due at the edge where the counter equals the register. A capture lands three edges after the pin changes: two synchronizer flops plus the latch. The bench drives inputs and samples outputs on falling edges. For captures it steps the counter by one at each edge, so that the captured value shows which edge did the latching. This checks the latency to the cycle and not only that a capture happened.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;
  localparam int IOC_W = 4;
  localparam int IER_W = 8;
  localparam logic [IER_W-1:0] IER_RST   = 8'h40;
  localparam logic [IER_W-1:0] IER_WMASK = 8'h9F;
  localparam int IER_OVF_BIT = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } cmp_act_e;
endpackage

// File: rtl/tmr_ccu_edge.sv
module tmr_ccu_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  // stage 0 samples the pin, stages up to STAGES-1 resolve metastability,
  // the last stage holds the previous synchronized sample
  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/tmr_ccu_ctl.sv
module tmr_ccu_ctl
  import tmr_ccu_pkg::*;
#(
  parameter int GR_SEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ioc_we,
  input  logic [IOC_W-1:0] ioc_wdata,
  input  logic             ier_we,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             cnt_ovf_i,
  input  logic             ovf_clr,
  input  logic             flag_i,
  output logic [IOC_W-1:0] ioc_q,
  output logic [IER_W-1:0] ier_rdata,
  output logic             irq_gr,
  output logic             irq_ovf
);
  logic [IOC_W-1:0] ioc_d;
  logic [IER_W-1:0] ier_q, ier_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    ioc_d = ioc_q;
    if (ioc_we) ioc_d = ioc_wdata;
    ier_d = ier_q;
    if (ier_we) ier_d = ier_wdata & IER_WMASK;
    ovf_d = ovf_q;
    if (cnt_ovf_i)    ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioc_q <= '0;
      ier_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ioc_q <= ioc_d;
      ier_q <= ier_d;
      ovf_q <= ovf_d;
    end
  end

  assign ier_rdata = ier_q | IER_RST;
  assign irq_gr    = flag_i & ier_q[GR_SEL];
  assign irq_ovf   = ovf_q & ier_q[IER_OVF_BIT];
endmodule

// File: rtl/tmr_ccu_gr.sv
module tmr_ccu_gr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          gr_we,
  input  logic [CW-1:0] gr_wdata,
  input  logic          cap_mode,
  input  logic [1:0]    sel,
  input  logic          buf_mode,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          flag_clr,
  output logic          match_ev,
  output logic [CW-1:0] gr_q,
  output logic          flag_o
);
  logic [CW-1:0] gr_d;
  logic          flag_d;
  logic          edge_hit;
  logic          cap_ev;

  always_comb begin
    if (sel[1])      edge_hit = rise_i | fall_i;
    else if (sel[0]) edge_hit = fall_i;
    else             edge_hit = rise_i;
    cap_ev   = cap_mode & ~buf_mode & edge_hit;
    match_ev = ~cap_mode & ~buf_mode & (cnt_i == gr_q);

    gr_d = gr_q;
    if (gr_we)       gr_d = gr_wdata;
    else if (cap_ev) gr_d = cnt_i;

    flag_d = flag_o;
    if (cap_ev || match_ev) flag_d = 1'b1;
    else if (flag_clr)      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_q   <= '0;
      flag_o <= 1'b0;
    end else begin
      gr_q   <= gr_d;
      flag_o <= flag_d;
    end
  end
endmodule

// File: rtl/tmr_ccu_pin.sv
module tmr_ccu_pin
  import tmr_ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_init,
  input  logic       init_lvl,
  input  logic       cmp_mode,
  input  logic [1:0] act_sel,
  input  logic       match_ev,
  output logic       pin_o,
  output logic       pin_oe
);
  logic     pin_d;
  cmp_act_e act;

  always_comb begin
    act   = cmp_act_e'(act_sel);
    pin_d = pin_o;
    if (load_init) begin
      pin_d = init_lvl;
    end else if (match_ev) begin
      case (act)
        ACT_LOW:  pin_d = 1'b0;
        ACT_HIGH: pin_d = 1'b1;
        ACT_TOG:  pin_d = ~pin_o;
        default:  pin_d = pin_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_o <= 1'b0;
    else        pin_o <= pin_d;
  end

  assign pin_oe = cmp_mode & (act != ACT_NONE);
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
  import tmr_ccu_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GR_SEL      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt_i,
  input  logic             cnt_ovf_i,
  input  logic             pin_i,
  input  logic             gr_we,
  input  logic [CW-1:0]    gr_wdata,
  input  logic             ioc_we,
  input  logic [IOC_W-1:0] ioc_wdata,
  input  logic             ier_we,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             buf_mode,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  output logic             pin_o,
  output logic             pin_oe,
  output logic [CW-1:0]    gr_q,
  output logic             flag_o,
  output logic [IER_W-1:0] ier_rdata,
  output logic             irq_gr,
  output logic             irq_ovf
);
  logic [1:0]       rst_pipe;
  logic             arst_sync_n;
  logic [IOC_W-1:0] ioc_q;
  logic             rise, fall, match_ev;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_sync_n = rst_pipe[1];

  tmr_ccu_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(arst_sync_n), .pin_i(pin_i),
    .rise_o(rise), .fall_o(fall)
  );

  tmr_ccu_ctl #(.GR_SEL(GR_SEL)) u_ctl (
    .clk(clk), .rst_n(arst_sync_n),
    .ioc_we(ioc_we), .ioc_wdata(ioc_wdata),
    .ier_we(ier_we), .ier_wdata(ier_wdata),
    .cnt_ovf_i(cnt_ovf_i), .ovf_clr(ovf_clr), .flag_i(flag_o),
    .ioc_q(ioc_q), .ier_rdata(ier_rdata),
    .irq_gr(irq_gr), .irq_ovf(irq_ovf)
  );

  tmr_ccu_gr #(.CW(CW)) u_gr (
    .clk(clk), .rst_n(arst_sync_n), .cnt_i(cnt_i),
    .gr_we(gr_we), .gr_wdata(gr_wdata),
    .cap_mode(ioc_q[3]), .sel(ioc_q[1:0]), .buf_mode(buf_mode),
    .rise_i(rise), .fall_i(fall), .flag_clr(flag_clr),
    .match_ev(match_ev), .gr_q(gr_q), .flag_o(flag_o)
  );

  tmr_ccu_pin u_pin (
    .clk(clk), .rst_n(arst_sync_n),
    .load_init(ioc_we & ~ioc_wdata[3]), .init_lvl(ioc_wdata[2]),
    .cmp_mode(~ioc_q[3]), .act_sel(ioc_q[1:0]), .match_ev(match_ev),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/tmr_ccu_chk.sv
module tmr_ccu_chk
  import tmr_ccu_pkg::*;
#(
  parameter int CW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    cnt_i,
  input logic             gr_we,
  input logic             ioc_we,
  input logic [IOC_W-1:0] ioc_wdata,
  input logic             ier_we,
  input logic [IER_W-1:0] ier_wdata,
  input logic             buf_mode,
  input logic [IOC_W-1:0] ioc_q,
  input logic             pin_o,
  input logic             pin_oe,
  input logic [CW-1:0]    gr_q,
  input logic             flag_o,
  input logic [IER_W-1:0] ier_rdata,
  input logic             irq_gr
);
  assert_ier_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier_rdata == (($past(ier_wdata) & IER_WMASK) | IER_RST));

  assert_init_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ioc_we && !ioc_wdata[3]) |=> pin_o == $past(ioc_wdata[2]));

  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ioc_q[3] && !buf_mode && cnt_i == gr_q) |=> flag_o);

  assert_cap_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_q[3] |-> !pin_oe);

  assert_buf_gr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !gr_we) |=> $stable(gr_q));

  assert_buf_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !ioc_we) |=> $stable(pin_o));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gr |-> flag_o);
endmodule

bind tmr_ccu tmr_ccu_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(arst_sync_n), .cnt_i(cnt_i), .gr_we(gr_we),
  .ioc_we(ioc_we), .ioc_wdata(ioc_wdata), .ier_we(ier_we),
  .ier_wdata(ier_wdata), .buf_mode(buf_mode), .ioc_q(ioc_q),
  .pin_o(pin_o), .pin_oe(pin_oe), .gr_q(gr_q), .flag_o(flag_o),
  .ier_rdata(ier_rdata), .irq_gr(irq_gr)
);

// File: tb/tmr_ccu_test.sv
`timescale 1ns/1ps
module tmr_ccu_test;
  localparam int CW = 16;
  localparam logic [CW-1:0] IDLE = 16'd5;
  localparam logic [CW-1:0] CMPV = 16'd100;

  logic clk = 1'b0;
  logic rst_n, cnt_ovf_i, pin_i, gr_we, ioc_we, ier_we, buf_mode, flag_clr, ovf_clr;
  logic [CW-1:0] cnt_i, gr_wdata, gr_q;
  logic [3:0] ioc_wdata;
  logic [7:0] ier_wdata, ier_rdata;
  logic pin_o, pin_oe, flag_o, irq_gr, irq_ovf;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tmr_ccu #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_ovf_i(cnt_ovf_i), .pin_i(pin_i),
    .gr_we(gr_we), .gr_wdata(gr_wdata), .ioc_we(ioc_we), .ioc_wdata(ioc_wdata),
    .ier_we(ier_we), .ier_wdata(ier_wdata), .buf_mode(buf_mode),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .pin_o(pin_o), .pin_oe(pin_oe),
    .gr_q(gr_q), .flag_o(flag_o), .ier_rdata(ier_rdata),
    .irq_gr(irq_gr), .irq_ovf(irq_ovf)
  );

  // {mode[3:0], initial level, output enable, level after one match}
  localparam logic [6:0] VEC [8] = '{
    7'b0000_0_0_0, 7'b0001_0_1_0, 7'b0010_0_1_1, 7'b0011_0_1_1,
    7'b0100_1_0_1, 7'b0101_1_1_0, 7'b0110_1_1_1, 7'b0111_1_1_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ioc(input logic [3:0] code);
    ioc_we = 1'b1; ioc_wdata = code; tick(); ioc_we = 1'b0;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_we = 1'b1; ier_wdata = v; tick(); ier_we = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  // drive a pin level, step the counter each edge; capture lands at the third edge
  task automatic pin_step(input logic lvl, input logic [CW-1:0] base);
    pin_i = lvl; cnt_i = base; tick();
    cnt_i = base + 1; tick();
    cnt_i = base + 2; tick();
    cnt_i = IDLE;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_i = IDLE; cnt_ovf_i = 0; pin_i = 0; gr_we = 0; gr_wdata = '0;
    ioc_we = 0; ioc_wdata = '0; ier_we = 0; ier_wdata = '0; buf_mode = 0;
    flag_clr = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_o", pin_o, 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 gr_q", gr_q, 0);
    check("R1 flag_o", flag_o, 0);
    check("R1 ier_rdata", ier_rdata, 8'h40);
    check("R1 irq", {irq_gr, irq_ovf}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 flag after release", flag_o, 0);

    // R2 enable register read-only bits
    wr_ier(8'hFF);
    check("R2 write ff", ier_rdata, 8'hDF);
    wr_ier(8'h00);
    check("R2 write 00", ier_rdata, 8'h40);

    gr_we = 1'b1; gr_wdata = CMPV; tick(); gr_we = 1'b0;
    check("R11 bus write", gr_q, CMPV);

    // R3 R4 R5 compare vectors
    for (int i = 0; i < 8; i++) begin
      wr_ioc(VEC[i][6:3]);
      check($sformatf("R3 init level code %b", VEC[i][6:3]), pin_o, VEC[i][2]);
      check($sformatf("R3 oe code %b", VEC[i][6:3]), pin_oe, VEC[i][1]);
      cnt_i = CMPV; tick(); cnt_i = IDLE;
      check($sformatf("R5 match action code %b", VEC[i][6:3]), pin_o, VEC[i][0]);
      check($sformatf("R4 match flag code %b", VEC[i][6:3]), flag_o, 1);
      clr_flag();
      check("R9 clear", flag_o, 0);
    end

    // R9 set wins over clear
    cnt_i = CMPV; flag_clr = 1'b1; tick(); cnt_i = IDLE; flag_clr = 1'b0;
    check("R9 set wins", flag_o, 1);
    clr_flag();

    // R10 interrupt gating
    cnt_i = CMPV; tick(); cnt_i = IDLE;
    check("R10 irq_gr gated off", irq_gr, 0);
    wr_ier(8'h04);
    check("R10 irq_gr enabled", irq_gr, 1);
    wr_ier(8'h10);
    check("R10 irq_gr other bit", irq_gr, 0);
    cnt_ovf_i = 1'b1; tick(); cnt_ovf_i = 1'b0;
    check("R10 irq_ovf", irq_ovf, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    check("R10 ovf clear", irq_ovf, 0);
    clr_flag();

    // R8 buffer mode suppresses compare
    wr_ioc(4'b0010);
    buf_mode = 1'b1;
    cnt_i = CMPV; tick(); cnt_i = IDLE;
    check("R8 buf pin hold", pin_o, 0);
    check("R8 buf no flag", flag_o, 0);
    buf_mode = 1'b0;

    // R6 capture
    wr_ioc(4'b1000);
    check("R6 capture oe", pin_oe, 0);
    pin_step(1'b1, 16'd10);
    check("R6 rising capture", gr_q, 16'd12);
    check("R6 capture flag", flag_o, 1);
    clr_flag();
    pin_step(1'b0, 16'd20);
    check("R6 falling ignored", gr_q, 16'd12);
    wr_ioc(4'b1001);
    pin_step(1'b1, 16'd30);
    check("R6 rising ignored", gr_q, 16'd12);
    pin_step(1'b0, 16'd40);
    check("R6 falling capture", gr_q, 16'd42);
    // R7 both edges
    wr_ioc(4'b1010);
    pin_step(1'b1, 16'd50);
    check("R7 both rise", gr_q, 16'd52);
    pin_step(1'b0, 16'd60);
    check("R7 both fall", gr_q, 16'd62);
    wr_ioc(4'b1011);
    pin_step(1'b1, 16'd70);
    check("R7 code 1011 rise", gr_q, 16'd72);
    clr_flag();

    // R8 buffer mode suppresses capture
    buf_mode = 1'b1;
    pin_step(1'b0, 16'd80);
    check("R8 buf gr hold", gr_q, 16'd72);
    check("R8 buf no cap flag", flag_o, 0);
    buf_mode = 1'b0;

    // R11 bus write beats capture in the same cycle
    pin_i = 1'b1; cnt_i = 16'd90; tick(); tick();
    gr_we = 1'b1; gr_wdata = 16'h0077; tick(); gr_we = 1'b0; cnt_i = IDLE;
    check("R11 write over capture", gr_q, 16'h0077);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule